// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that behaves like a byte-wide serial EEPROM. It watches oversampled SCL and SDA lines, finds START and STOP conditions, and checks the device-select byte against three strap inputs. It takes a two-byte word address and then runs one of three kinds of access: a byte or page write, a random read, or a current-address or sequential read. Its only output is an open-drain enable that pulls SDA low.

Write data does not go straight into the array. It is collected in a page buffer, and the buffer offset wraps inside the current page. A STOP that follows a complete, acknowledged data byte hands the buffer to a write-cycle controller. That controller copies the written bytes into the array, one byte per clock, during a fixed busy window. While the window is open, the target refuses its device-select byte, so a bus master can poll for completion.

The array is an inferred register array of 2^ADDR_W bytes, with ADDR_W up to 15. It resets to the erased value FFh.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset, the SDA pull-down enable is off and every array location reads back FFh.
- R2: The target acknowledges a device-select byte only when all of these hold: bits 7:4 are 1010, bits 3:1 equal `strap_i`, and no write cycle is running. Bit 0 set to 1 selects a read. Any other device-select byte gets no acknowledge, and the target ignores the bus until the next START.
- R3: The target captures SDA at SCL rising edges. The SDA enable changes only after an SCL falling edge, apart from a release at START or STOP.
- R4: Two address bytes follow a write-type device select, high byte first. Only the low ADDR_W bits of the 16 received bits are used.
- R5: Each write data byte goes to the current address. The low log2(PAGE_BYTES) address bits then increment and wrap inside the page, and the upper bits stay fixed. Locations of the page that were not written keep their old contents.
- R6: Nothing reaches the array until a STOP arrives right after a complete, acknowledged data byte. A repeated START discards buffered write data.
- R7: A START or STOP that arrives after two or more bits of a data byte aborts the transfer, and none of its data is committed.
- R8: A committed write keeps the target busy for WR_CYCLES clocks. During that time its device-select byte gets no acknowledge. Afterwards it is acknowledged again.
- R9: A random read works as follows: send a write-type device select and the address, then a repeated START and a read-type device select. The read returns the byte at that address.
- R10: A current-address read starts at the address that follows the last byte read or written.
- R11: During a read, a master ACK moves on to the next byte, and the address wraps from the last location back to 0. A master NACK ends the driving of data.
- R12: In an addressed transfer, the target acknowledges every address byte and every write data byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| strap_i | input | 3 | Chip-address straps compared with device-select bits 3:1 |
| sda_oe_o | output | 1 | Pulls SDA low when 1 (open drain) |

## Verification
The hardest situation to reach from the ports is the busy window. The target only refuses its own device-select byte while a committed page is still being copied into the array. The bench sets WR_CYCLES longer than one select-byte transaction and starts polling straight after the committing STOP, so the first poll must land inside the window and get no acknowledge. Aborts are also hard to reach, because they require a START or STOP placed in the middle of a byte. The bench reaches them by clocking a partial data byte after a fully acknowledged one, and by sending a repeated START after buffered data. It then reads the locations back to confirm that nothing was committed.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACKWAIT,
    ST_ACK,
    ST_TX,
    ST_TXEND,
    ST_RACK,
    ST_RACKEND
  } ee_state_t;

  typedef enum logic [1:0] {
    K_DEV,
    K_AHI,
    K_ALO,
    K_DATA
  } rx_kind_t;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;

endpackage

// File: rtl/i2c_ee_linefront.sv
module i2c_ee_linefront #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s    = scl_sync[SYNC_STAGES-1];
  assign sda_s    = sda_sync[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & ~sda_s & sda_q;
  assign stop_ev  = scl_s & scl_q & sda_s & ~sda_q;

endmodule

// File: rtl/i2c_ee_pagebuf.sv
module i2c_ee_pagebuf #(
  parameter int PAGE_BYTES = 32,
  localparam int PO = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PO-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic          clr,
  input  logic [PO-1:0] ridx,
  output logic [7:0]    rdata,
  output logic          rvalid
);

  logic [7:0]            data [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask, mask_n;

  always_comb begin
    mask_n = mask;
    if (clr)     mask_n = '0;
    else if (we) mask_n[widx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else        mask <= mask_n;
  end

  always_ff @(posedge clk) begin
    if (we) data[widx] <= wdata;
  end

  assign rdata  = data[ridx];
  assign rvalid = mask[ridx];

endmodule

// File: rtl/i2c_ee_array.sv
module i2c_ee_array #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 32,
  parameter int WR_CYCLES  = 4000,
  localparam int PO    = $clog2(PAGE_BYTES),
  localparam int DEPTH = 1 << ADDR_W,
  localparam int CW    = $clog2(WR_CYCLES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [7:0]         rd_data,
  input  logic               commit,
  input  logic [ADDR_W-PO-1:0] commit_base,
  output logic [PO-1:0]      buf_idx,
  input  logic [7:0]         buf_data,
  input  logic               buf_valid,
  output logic               busy
);

  logic [7:0]          mem [DEPTH];
  logic                busy_n;
  logic [CW-1:0]       wcnt, wcnt_n;
  logic [ADDR_W-PO-1:0] base, base_n;
  logic                we;

  always_comb begin
    busy_n = busy;
    wcnt_n = wcnt;
    base_n = base;
    if (!busy && commit) begin
      busy_n = 1'b1;
      wcnt_n = '0;
      base_n = commit_base;
    end else if (busy) begin
      wcnt_n = wcnt + 1'b1;
      if (wcnt == CW'(WR_CYCLES - 1)) busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      wcnt <= '0;
      base <= '0;
    end else begin
      busy <= busy_n;
      wcnt <= wcnt_n;
      base <= base_n;
    end
  end

  assign buf_idx = wcnt[PO-1:0];
  assign we      = busy && (wcnt < CW'(PAGE_BYTES)) && buf_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (we) begin
      mem[{base, buf_idx}] <= buf_data;
    end
  end

  assign rd_data = mem[rd_addr];

  // R8: a commit while idle opens the write window on the next clock
  a_r8_commit_opens_window: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !busy) |=> busy);
  // R8: the window never closes before its first clock is done
  a_r8_window_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (wcnt == '0));

endmodule

// File: rtl/i2c_ee_proto.sv
module i2c_ee_proto
  import i2c_ee_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 32,
  localparam int PO   = $clog2(PAGE_BYTES),
  localparam int HI_W = ADDR_W - 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sda_s,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_ev,
  input  logic                 stop_ev,
  input  logic [2:0]           strap,
  input  logic                 busy,
  input  logic [7:0]           rd_data,
  output logic [ADDR_W-1:0]    ptr,
  output logic                 sda_oe,
  output logic                 buf_we,
  output logic [PO-1:0]        buf_idx,
  output logic [7:0]           buf_wdata,
  output logic                 buf_clr,
  output logic                 commit,
  output logic [ADDR_W-PO-1:0] commit_base
);

  ee_state_t          st, st_n;
  rx_kind_t           kind, kind_n;
  logic [2:0]         cnt, cnt_n;
  logic [7:0]         sh, sh_n, full;
  logic               rw, rw_n;
  logic [HI_W-1:0]    ahi, ahi_n;
  logic [ADDR_W-1:0]  ptr_n;
  logic               has_data, has_n;
  logic               oe_n, commit_n;

  assign full = {sh[6:0], sda_s};

  always_comb begin
    st_n     = st;
    kind_n   = kind;
    cnt_n    = cnt;
    sh_n     = sh;
    rw_n     = rw;
    ahi_n    = ahi;
    ptr_n    = ptr;
    has_n    = has_data;
    oe_n     = sda_oe;
    commit_n = 1'b0;
    buf_we   = 1'b0;
    buf_clr  = 1'b0;
    if (start_ev) begin
      st_n   = ST_RX;
      kind_n = K_DEV;
      cnt_n  = '0;
      oe_n   = 1'b0;
      has_n  = 1'b0;
    end else if (stop_ev) begin
      commit_n = (st == ST_RX) && (kind == K_DATA) && (cnt == 3'd1) && has_data;
      st_n     = ST_IDLE;
      oe_n     = 1'b0;
      has_n    = 1'b0;
    end else begin
      case (st)
        ST_RX: if (scl_rise) begin
          sh_n  = full;
          cnt_n = cnt + 3'd1;
          if (cnt == 3'd7) begin
            st_n = ST_ACKWAIT;
            case (kind)
              K_DEV: begin
                rw_n = full[0];
                if (full[7:4] != DEV_PREFIX || full[3:1] != strap || busy) st_n = ST_IDLE;
              end
              K_AHI: ahi_n = full[HI_W-1:0];
              K_ALO: begin
                ptr_n   = {ahi, full};
                buf_clr = 1'b1;
              end
              default: begin
                buf_we = 1'b1;
                ptr_n  = {ptr[ADDR_W-1:PO], ptr[PO-1:0] + PO'(1)};
                has_n  = 1'b1;
              end
            endcase
          end
        end
        ST_ACKWAIT: if (scl_fall) begin
          oe_n = 1'b1;
          st_n = ST_ACK;
        end
        ST_ACK: if (scl_fall) begin
          cnt_n = '0;
          oe_n  = 1'b0;
          st_n  = ST_RX;
          case (kind)
            K_DEV: if (rw) begin
              st_n = ST_TX;
              sh_n = rd_data;
              oe_n = ~rd_data[7];
            end else kind_n = K_AHI;
            K_AHI:   kind_n = K_ALO;
            default: kind_n = K_DATA;
          endcase
        end
        ST_TX: if (scl_rise) begin
          cnt_n = cnt + 3'd1;
          if (cnt == 3'd7) begin
            st_n  = ST_TXEND;
            ptr_n = ptr + 1'b1;
          end
        end else if (scl_fall) begin
          oe_n = ~sh[6];
          sh_n = {sh[6:0], 1'b0};
        end
        ST_TXEND: if (scl_fall) begin
          oe_n = 1'b0;
          st_n = ST_RACK;
        end
        ST_RACK: if (scl_rise) st_n = sda_s ? ST_IDLE : ST_RACKEND;
        ST_RACKEND: if (scl_fall) begin
          sh_n  = rd_data;
          oe_n  = ~rd_data[7];
          cnt_n = '0;
          st_n  = ST_TX;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      kind     <= K_DEV;
      cnt      <= '0;
      sh       <= '0;
      rw       <= 1'b0;
      ahi      <= '0;
      ptr      <= '0;
      has_data <= 1'b0;
      sda_oe   <= 1'b0;
      commit   <= 1'b0;
    end else begin
      st       <= st_n;
      kind     <= kind_n;
      cnt      <= cnt_n;
      sh       <= sh_n;
      rw       <= rw_n;
      ahi      <= ahi_n;
      ptr      <= ptr_n;
      has_data <= has_n;
      sda_oe   <= oe_n;
      commit   <= commit_n;
    end
  end

  assign buf_idx     = ptr[PO-1:0];
  assign buf_wdata   = full;
  assign commit_base = ptr[ADDR_W-1:PO];

  // R3: the pull-down only moves after an SCL fall, START or STOP
  a_r3_oe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_ev) || $past(stop_ev)));
  // R8: no device-select acknowledge during a write cycle
  a_r8_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACK && kind == K_DEV && sda_oe) |-> !busy);
  // R5: page-write stepping keeps the page number
  a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |=> (ptr[ADDR_W-1:PO] == $past(ptr[ADDR_W-1:PO])));
  // R11: each transmitted byte advances the address by one, wrapping
  a_r11_read_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TX && scl_rise && cnt == 3'd7 && !start_ev && !stop_ev) |=> (ptr == $past(ptr) + 1'b1));
  // R6: a commit is only issued right after a STOP
  a_r6_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(stop_ev));

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int ADDR_W      = 11,
  parameter int PAGE_BYTES  = 32,
  parameter int WR_CYCLES   = 4000,
  parameter int SYNC_STAGES = 2,
  localparam int PO = $clog2(PAGE_BYTES)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe_o
);

  logic [1:0] rst_sync;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [ADDR_W-1:0]    ptr;
  logic [7:0]           rd_data, buf_wdata, buf_rdata;
  logic                 buf_we, buf_clr, buf_valid, commit, busy;
  logic [PO-1:0]        buf_widx, buf_ridx;
  logic [ADDR_W-PO-1:0] commit_base;

  i2c_ee_linefront #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_ns), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_ee_proto #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_proto (
    .clk(clk), .rst_n(rst_ns), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .strap(strap_i), .busy(busy), .rd_data(rd_data), .ptr(ptr),
    .sda_oe(sda_oe_o), .buf_we(buf_we), .buf_idx(buf_widx),
    .buf_wdata(buf_wdata), .buf_clr(buf_clr), .commit(commit),
    .commit_base(commit_base)
  );

  i2c_ee_pagebuf #(.PAGE_BYTES(PAGE_BYTES)) u_pbuf (
    .clk(clk), .rst_n(rst_ns), .we(buf_we), .widx(buf_widx),
    .wdata(buf_wdata), .clr(buf_clr), .ridx(buf_ridx),
    .rdata(buf_rdata), .rvalid(buf_valid)
  );

  i2c_ee_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)) u_array (
    .clk(clk), .rst_n(rst_ns), .rd_addr(ptr), .rd_data(rd_data),
    .commit(commit), .commit_base(commit_base), .buf_idx(buf_ridx),
    .buf_data(buf_rdata), .buf_valid(buf_valid), .busy(busy)
  );

endmodule

// File: tb/test_i2c_eeprom_target.sv
module test_i2c_eeprom_target;
  localparam int AW = 11, PB = 32, WRC = 700, Q = 8, DEPTH = 1 << AW;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEVW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEVR = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_b = 1'b1, sda_b = 1'b1;
  logic sda_oe, sda_line, oe_prev = 1'b0;
  int checks = 0, errors = 0;
  logic [7:0] ref_mem [DEPTH];
  int ref_ptr = 0;
  logic [7:0] wq[$];

  always #2 clk = ~clk;
  assign sda_line = sda_b & ~sda_oe;

  i2c_eeprom_target #(.ADDR_W(AW), .PAGE_BYTES(PB), .WR_CYCLES(WRC)) i_i2c_eeprom_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_b), .sda_i(sda_line),
    .strap_i(STRAP), .sda_oe_o(sda_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R3: compared every clock; the pull-down may only move while SCL is low
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe !== oe_prev) check(scl_b == 1'b0, "R3 oe moved while SCL high", scl_b, 0);
      oe_prev = sda_oe;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_b = 1'b1; tick(Q); scl_b = 1'b1; tick(Q); sda_b = 1'b0; tick(Q); scl_b = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_b = 1'b0; tick(Q); scl_b = 1'b1; tick(Q); sda_b = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_b = b; tick(Q); scl_b = 1'b1; tick(2 * Q); scl_b = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    sda_b = 1'b1; tick(Q); scl_b = 1'b1; tick(Q);
    ack = (sda_line == 1'b0);
    tick(Q); scl_b = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_b = 1'b1; tick(Q); scl_b = 1'b1; tick(Q);
      d[i] = sda_line;
      tick(Q); scl_b = 1'b0; tick(Q);
    end
    send_bit(mack);
  endtask

  task automatic addr_phase(input logic [15:0] a);
    logic ack;
    i2c_start();
    send_byte(DEVW, ack); check(ack, "R2 device select ack", ack, 1);
    send_byte(a[15:8], ack); check(ack, "R12 high address ack", ack, 1);
    send_byte(a[7:0], ack);  check(ack, "R12 low address ack", ack, 1);
  endtask

  task automatic write_txn(input logic [15:0] a);
    logic ack;
    int base, off;
    addr_phase(a);
    foreach (wq[i]) begin
      send_byte(wq[i], ack); check(ack, "R12 data byte ack", ack, 1);
    end
    i2c_stop();
    base = (int'(a) % DEPTH) & ~(PB - 1);
    off  = int'(a) % PB;
    foreach (wq[i]) begin
      ref_mem[base + off] = wq[i];
      off = (off + 1) % PB;
    end
    ref_ptr = base + off;
  endtask

  task automatic wait_ready(output int tries, output bit got);
    logic ack;
    tries = 0; got = 1'b0;
    while (!got && tries < 20) begin
      i2c_start(); send_byte(DEVW, ack); i2c_stop();
      if (ack) got = 1'b1; else tries++;
    end
  endtask

  task automatic read_body(input int n, input string req);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      recv_byte((i == n - 1), d);
      check(d == ref_mem[ref_ptr], req, d, ref_mem[ref_ptr]);
      ref_ptr = (ref_ptr + 1) % DEPTH;
    end
    i2c_stop();
  endtask

  task automatic rand_read(input logic [15:0] a, input int n, input string req);
    logic ack;
    addr_phase(a);
    i2c_start();
    send_byte(DEVR, ack); check(ack, "R9 read select ack", ack, 1);
    ref_ptr = int'(a) % DEPTH;
    read_body(n, req);
  endtask

  task automatic cur_read(input int n, input string req);
    logic ack;
    i2c_start();
    send_byte(DEVR, ack); check(ack, "R10 read select ack", ack, 1);
    read_body(n, req);
  endtask

  initial begin
    logic ack;
    int tries;
    bit got;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    tick(5);
    check(sda_oe == 1'b0, "R1 oe released in reset", sda_oe, 0);
    rst_n = 1'b1;
    tick(10);
    check(sda_oe == 1'b0, "R1 oe released after reset", sda_oe, 0);
    rand_read(16'h0123, 2, "R1 erased value / R9 random read");

    // R2: wrong strap, wrong prefix, then bus ignored until START
    i2c_start(); send_byte({4'b1010, 3'b010, 1'b0}, ack); check(!ack, "R2 wrong strap nack", ack, 0);
    send_byte(DEVW, ack); check(!ack, "R2 ignored until START", ack, 0); i2c_stop();
    i2c_start(); send_byte({4'b1011, STRAP, 1'b0}, ack); check(!ack, "R2 wrong prefix nack", ack, 0); i2c_stop();

    // R8: byte write, then acknowledge polling
    wq = '{8'hA5}; write_txn(16'h0045);
    wait_ready(tries, got);
    check(tries >= 1, "R8 busy select nack", tries, 1);
    check(got, "R8 ack after write cycle", got, 1);
    rand_read(16'h0045, 1, "R6 byte committed on STOP");

    // R5: page write wrapping inside the page
    wq = '{8'h10, 8'h11, 8'h12, 8'h13}; write_txn(16'h005E);
    wait_ready(tries, got); check(got, "R8 ready after page", got, 1);
    rand_read(16'h0040, 8, "R5 page wrap and untouched bytes");
    rand_read(16'h005E, 2, "R5 page tail");

    // R4: upper address bits ignored
    wq = '{8'hC7}; write_txn(16'hF9A3);
    wait_ready(tries, got); check(got, "R8 ready after R4 write", got, 1);
    rand_read(16'h01A3, 1, "R4 upper bits ignored");

    // R6: repeated START discards buffered data
    addr_phase(16'h0100);
    send_byte(8'h11, ack); check(ack, "R12 data ack before restart", ack, 1);
    i2c_start();
    send_byte(DEVW, ack); check(ack, "R6 no write cycle after restart", ack, 1);
    i2c_stop();
    rand_read(16'h0100, 1, "R6 discarded on repeated START");

    // R7: STOP in the middle of a data byte
    addr_phase(16'h0101);
    send_byte(8'h77, ack); check(ack, "R12 data ack before abort", ack, 1);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    i2c_stop();
    wait_ready(tries, got);
    check(tries == 0, "R7 aborted write starts no cycle", tries, 0);
    rand_read(16'h0102, 1, "R7 aborted data not committed");
    rand_read(16'h0101, 1, "R7 aborted data not committed");

    // R11 / R10: sequential wrap, then current-address read
    wq = '{8'h3C}; write_txn(16'h07FF);
    wait_ready(tries, got); check(got, "R8 ready after top write", got, 1);
    wq = '{8'h5A, 8'h6B}; write_txn(16'h0000);
    wait_ready(tries, got); check(got, "R8 ready after low write", got, 1);
    rand_read(16'h07FE, 3, "R11 sequential wrap to zero");
    check(sda_oe == 1'b0, "R11 released after NACK", sda_oe, 0);
    cur_read(1, "R10 current address read");
    cur_read(2, "R10 current address continues");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule